// File: doc/BRIEF.md
# Trapezoidal Pulse Shaper with Moving-Window Deconvolution

This block shapes a stream of signed ADC samples taken from a charge preamplifier whose output decays exponentially. It works in two stages. The first stage removes the exponential decay: it turns each decaying pulse into a rectangle that is L samples long. The second stage averages the last K results of the first stage, so the rectangle becomes a symmetric trapezoid. The trapezoid has a K-sample rise, a K-sample fall, and a flat top whose height is the pulse amplitude.

The first stage keeps a running window sum, updated recursively. A sample enters the sum at the head, and the sample L positions older leaves it at the tail. That old sample is read from a ring buffer. The write pointer of the ring buffer advances on every accepted sample, and the read address trails it by L. The second stage uses the same head-in, tail-out structure to form its K-term sum. The division by K is an arithmetic shift.

The parameters L, K (given as log2 K) and the decay coefficient c = 1/tau are set at run time. They are meant to be held steady between resets.

Top module: `mwd_trap_shaper`

## Requirements
- R1: While `rst` is high at a rising edge, the next state of the block has `shp_vld` = 0 and `shp_data` = 0.
- R2: Samples are two's complement, and the samples before the first one accepted after reset count as 0. `inv_tau` is the unsigned coefficient c with 16 fractional bits. For accepted sample n, D(n) = (x[n] - x[n-L])·2^16 + c·(x[n-1] + ... + x[n-L]). The output is `shp_data` = floor((D(n) + D(n-1) + ... + D(n-K+1)) / (K·2^16)), with L = `win_len` and K = 2^`avg_log2`.
- R3: Take c = 0 and a step of height H that starts after priming. The output has exactly K-1 values strictly between 0 and H while rising, then exactly L-K+1 values equal to H, then exactly K-1 values strictly between 0 and H while falling. The value just before the step and the value K+L-1 samples after the step start are both 0.
- R4: Take an input x[s] = A with x[m+1] = x[m] - floor(x[m]·c/2^16), and c matching the decay. Each output whose K-window lies inside the rectangle is within L+1 counts of A. Each output after the trapezoid has ended is within L+1 counts of 0.
- R5: A cycle with `smp_vld` low changes no stored state and produces no output. The results for a stream that has idle gaps equal the results for the same samples sent back to back.
- R6: A sample captured at rising edge e gives its result in the single cycle that follows rising edge e+1, with `shp_vld` high in that cycle only.
- R7: The first L+K-1 accepted samples after reset give no `shp_vld` pulse. Every accepted sample after them gives exactly one.
- R8: With L = 64, K = 32, c = 2^18-1 and full-scale inputs of +8191 and -8192, R2 holds exactly, with no internal overflow.
- R9: Any L from 2 to 64 with `avg_log2` from 0 to 5 and K < L is supported. This includes the smallest case, L = 2 and K = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe; the sample is taken at the rising edge |
| smp_data | input | 14 | Signed ADC sample |
| win_len | input | 7 | Deconvolution window L, from 2 to 64 |
| avg_log2 | input | 3 | log2 of the averaging length K, from 0 to 5 |
| inv_tau | input | 18 | Coefficient 1/tau, unsigned, 16 fractional bits |
| shp_vld | output | 1 | One-cycle pulse when a shaped value is ready |
| shp_data | output | 24 | Signed shaped value |

## Verification
Each result is registered twice, so the value for a sample captured at edge e is present between edges e+1 and e+2. The bench keeps its own two-stage record of which sample index was captured at each edge. It samples the outputs on the falling edge and compares them against the sample index it recorded two edges back. In that same cycle it also checks whether `shp_vld` should be high under the priming rule. Scenario-level checks are made once the last sample has fully drained. These cover the trapezoid shape, the exponential flatness, the idle-gap equivalence and the priming count.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
    // default datapath sizing
    localparam int SMP_W   = 14;
    localparam int COEF_W  = 18;
    localparam int FRAC_W  = 16;
    localparam int MAX_WIN = 64;
    localparam int MAX_AVG = 32;

    // sideband that travels with each sample through the pipeline
    typedef struct packed {
        logic vld;
        logic primed;
    } tag_t;

    // averaging length from its log2 code
    function automatic int unsigned avg_len(input int unsigned lg);
        return 32'd1 << lg;
    endfunction
endpackage

// File: rtl/mwd_delay.sv
module mwd_delay #(
    parameter int W     = 14,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int LAGW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic [LAGW-1:0] lag,      // 1..DEPTH samples back
    output logic [W-1:0]  old_data
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] raddr;

    // lag == DEPTH wraps onto the slot about to be overwritten
    assign raddr    = wptr - lag[AW-1:0];
    assign old_data = mem[raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wptr] <= wr_data;
            wptr      <= wptr + 1'b1;
        end
    end
endmodule

// File: rtl/mwd_deconv.sv
module mwd_deconv
    import mwd_pkg::*;
#(
    parameter int XW    = SMP_W,
    parameter int CW    = COEF_W,
    parameter int FW    = FRAC_W,
    parameter int DEPTH = MAX_WIN,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1,
    localparam int ACCW = XW + AW,
    localparam int DW   = ACCW + CW + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  tag_t                 in_tag,
    input  logic signed [XW-1:0] x,
    input  logic [LW-1:0]        win_len,
    input  logic [CW-1:0]        coef,
    output tag_t                 d_tag,
    output logic signed [DW-1:0] d_val
);
    logic signed [XW-1:0]   x_old;
    logic signed [XW:0]     diff;
    logic signed [ACCW-1:0] acc_q;
    logic signed [DW-1:0]   head_term;
    logic signed [DW-1:0]   sum_term;
    logic signed [DW-1:0]   d_val_q;
    tag_t                   tag_q;

    mwd_delay #(.W(XW), .DEPTH(DEPTH)) u_xline (
        .clk(clk), .rst(rst), .wr_en(in_tag.vld),
        .wr_data(x), .lag(win_len), .old_data(x_old)
    );

    assign diff      = XW'(x) - XW'(x_old) + (XW+1)'(0);
    assign head_term = DW'(diff) <<< FW;
    assign sum_term  = DW'($signed({1'b0, coef})) * DW'(acc_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            d_val_q <= '0;
            tag_q   <= '0;
        end else begin
            tag_q <= in_tag;
            if (in_tag.vld) begin
                acc_q   <= acc_q + ACCW'(diff);
                d_val_q <= head_term + sum_term;
            end
        end
    end

    assign d_tag = tag_q;
    assign d_val = d_val_q;

    // R5: an idle input cycle leaves the window sum and result untouched
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_tag.vld |=> $stable(acc_q) && $stable(d_val_q));
endmodule

// File: rtl/mwd_boxcar.sv
module mwd_boxcar
    import mwd_pkg::*;
#(
    parameter int DW    = 40,
    parameter int FW    = FRAC_W,
    parameter int DEPTH = MAX_AVG,
    parameter int OW    = 24,
    localparam int AW   = $clog2(DEPTH),
    localparam int SW   = DW + AW,
    localparam int SHW  = $clog2(AW + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  tag_t                 d_tag,
    input  logic signed [DW-1:0] d_val,
    input  logic [SHW-1:0]       avg_log2,
    output tag_t                 y_tag,
    output logic signed [OW-1:0] y_val
);
    logic [AW:0]            lag;
    logic signed [DW-1:0]   d_old;
    logic signed [SW-1:0]   sum_q;
    logic signed [SW-1:0]   sum_next;
    logic signed [SW-1:0]   scaled;
    logic signed [OW-1:0]   y_q;
    tag_t                   tag_q;

    assign lag = (AW+1)'(avg_len(32'(avg_log2)));

    mwd_delay #(.W(DW), .DEPTH(DEPTH)) u_dline (
        .clk(clk), .rst(rst), .wr_en(d_tag.vld),
        .wr_data(d_val), .lag(lag), .old_data(d_old)
    );

    assign sum_next = sum_q + SW'(d_val) - SW'(d_old);
    assign scaled   = sum_next >>> (FW + int'(avg_log2));

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            y_q   <= '0;
            tag_q <= '0;
        end else begin
            tag_q <= d_tag;
            if (d_tag.vld) begin
                sum_q <= sum_next;
                y_q   <= OW'(scaled);
            end
        end
    end

    assign y_tag = tag_q;
    assign y_val = y_q;

    // R5: no new stage-one result means the average and output hold
    a_r5_box_hold: assert property (@(posedge clk) disable iff (rst)
        !d_tag.vld |=> $stable(sum_q) && $stable(y_q));
endmodule

// File: rtl/mwd_trap_shaper.sv
module mwd_trap_shaper
    import mwd_pkg::*;
#(
    parameter int SMP_BITS  = SMP_W,
    parameter int COEF_BITS = COEF_W,
    parameter int FRAC_BITS = FRAC_W,
    parameter int WIN_MAX   = MAX_WIN,
    parameter int AVG_MAX   = MAX_AVG,
    localparam int WLW  = $clog2(WIN_MAX) + 1,
    localparam int ASW  = $clog2($clog2(AVG_MAX) + 1),
    localparam int DECB = SMP_BITS + $clog2(WIN_MAX) + COEF_BITS + 2,
    localparam int OUTB = DECB - FRAC_BITS,
    localparam int CNTW = WLW + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_vld,
    input  logic signed [SMP_BITS-1:0] smp_data,
    input  logic [WLW-1:0]             win_len,
    input  logic [ASW-1:0]             avg_log2,
    input  logic [COEF_BITS-1:0]       inv_tau,
    output logic                       shp_vld,
    output logic signed [OUTB-1:0]     shp_data
);
    logic [CNTW-1:0]        cnt_q;
    logic [CNTW-1:0]        lk_total;
    tag_t                   in_tag, d_tag, y_tag;
    logic signed [DECB-1:0] d_val;

    // samples needed before both delay lines hold real history
    assign lk_total = CNTW'(win_len) + CNTW'(avg_len(32'(avg_log2)));

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (smp_vld && cnt_q < lk_total)
            cnt_q <= cnt_q + 1'b1;
    end

    assign in_tag.vld    = smp_vld;
    assign in_tag.primed = (cnt_q + CNTW'(1)) >= lk_total;

    mwd_deconv #(
        .XW(SMP_BITS), .CW(COEF_BITS), .FW(FRAC_BITS), .DEPTH(WIN_MAX)
    ) u_deconv (
        .clk(clk), .rst(rst), .in_tag(in_tag), .x(smp_data),
        .win_len(win_len), .coef(inv_tau), .d_tag(d_tag), .d_val(d_val)
    );

    mwd_boxcar #(
        .DW(DECB), .FW(FRAC_BITS), .DEPTH(AVG_MAX), .OW(OUTB)
    ) u_boxcar (
        .clk(clk), .rst(rst), .d_tag(d_tag), .d_val(d_val),
        .avg_log2(avg_log2), .y_tag(y_tag), .y_val(shp_data)
    );

    assign shp_vld = y_tag.vld & y_tag.primed;

    // R6: a result pulse always traces back to a sample two edges earlier
    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        shp_vld |-> $past(smp_vld, 2));

    // R7: no result before the priming count has been reached
    a_r7_priming: assert property (@(posedge clk) disable iff (rst)
        shp_vld |-> cnt_q == lk_total);

    // R6: a result lasts one cycle unless a new sample followed directly
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        shp_vld && !$past(smp_vld) |=> !shp_vld);
endmodule

// File: tb/mwd_trap_shaper_bench.sv
`timescale 1ns/1ps
module mwd_trap_shaper_bench;
    logic               clk = 1'b0;
    logic               rst;
    logic               smp_vld;
    logic signed [13:0] smp_data;
    logic [6:0]         win_len;
    logic [2:0]         avg_log2;
    logic [17:0]        inv_tau;
    logic               shp_vld;
    logic signed [23:0] shp_data;

    always #4 clk = ~clk;

    mwd_trap_shaper u_mwd_trap_shaper (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
        .win_len(win_len), .avg_log2(avg_log2), .inv_tau(inv_tau),
        .shp_vld(shp_vld), .shp_data(shp_data)
    );

    localparam longint NONE = -(64'sd1 <<< 40);

    int     cfg_l, cfg_k, cfg_ksh;
    longint cfg_c;
    int     xs [0:1023];
    longint outv [0:1023];
    int     vcount;
    int     checks = 0;
    int     errors = 0;
    int     cur_idx = -1;
    int     hist0 = -1;
    int     hist1 = -1;
    bit     mon_en = 1'b0;
    bit     done = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    // ---------------- reference model (from R2) ----------------
    function automatic longint xv(int i);
        return (i < 0) ? 0 : longint'(xs[i]);
    endfunction

    function automatic longint dval(int n);
        longint a;
        if (n < 0) return 0;
        a = 0;
        for (int i = 1; i <= cfg_l; i++) a += xv(n - i);
        return (xv(n) - xv(n - cfg_l)) * 65536 + cfg_c * a;
    endfunction

    function automatic longint yexp(int n);
        longint s;
        s = 0;
        for (int j = 0; j < cfg_k; j++) s += dval(n - j);
        return s >>> (16 + cfg_ksh);
    endfunction

    function automatic int rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'(seed[29:16]) - 8192;
    endfunction

    task automatic chk(bit ok, string r, string what, longint got, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", r, what, got, exp);
        end
    endtask

    // capture history: which sample index each edge took in
    always @(posedge clk) begin
        hist1 <= hist0;
        hist0 <= smp_vld ? cur_idx : -1;
    end

    // R2 R6 R7: per-cycle result monitor, one cycle after the second edge
    always @(negedge clk) begin
        bit     ev;
        longint e;
        if (mon_en) begin
            ev = (hist1 >= 0) && (hist1 >= cfg_l + cfg_k - 1);
            chk(shp_vld === ev, "R6 R7", "valid timing", longint'(shp_vld), longint'(ev));
            if (ev) begin
                e = yexp(hist1);
                chk(longint'(shp_data) == e, "R2", "shaped value", longint'(shp_data), e);
            end
            if (shp_vld === 1'b1 && hist1 >= 0) begin
                outv[hist1] = longint'(shp_data);
                vcount++;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic do_reset();
        mon_en  = 1'b0;
        smp_vld = 1'b0;
        rst     = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset is held
        chk(shp_vld === 1'b0, "R1", "reset valid", longint'(shp_vld), 0);
        chk(shp_data === 24'sd0, "R1", "reset data", longint'(shp_data), 0);
        rst     = 1'b0;
        cur_idx = -1;
        mon_en  = 1'b1;
    endtask

    task automatic begin_scn(int l, int ksh, longint c);
        cfg_l    = l;
        cfg_ksh  = ksh;
        cfg_k    = 1 << ksh;
        cfg_c    = c;
        win_len  = 7'(l);
        avg_log2 = 3'(ksh);
        inv_tau  = 18'(c);
        for (int i = 0; i < 1024; i++) begin
            outv[i] = NONE;
            xs[i]   = 0;
        end
        vcount = 0;
        do_reset();
    endtask

    task automatic stream(int n, int gap);
        for (int i = 0; i < n; i++) begin
            if (gap > 0 && (i % gap) == gap - 1) begin
                @(negedge clk);
                smp_vld = 1'b0;
                smp_data = 14'sh2aa; // junk on an idle cycle, must be ignored
            end
            @(negedge clk);
            smp_vld  = 1'b1;
            smp_data = 14'(xs[i]);
            cur_idx  = i;
        end
        @(negedge clk);
        smp_vld = 1'b0;
        cur_idx = -1;
        repeat (4) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_step();
        int s, n, full, part;
        begin_scn(20, 3, 0);
        s = cfg_l + cfg_k + 5;
        n = s + cfg_l + cfg_k + 6;
        for (int i = 0; i < n; i++) xs[i] = (i < s) ? 0 : 1000;
        stream(n, 0);
        full = 0;
        part = 0;
        for (int i = 0; i < n; i++) begin
            if (outv[i] == 1000) full++;
            else if (outv[i] > 0 && outv[i] < 1000) part++;
        end
        chk(full == cfg_l - cfg_k + 1, "R3", "flat-top length", full, cfg_l - cfg_k + 1);
        chk(part == 2 * (cfg_k - 1), "R3", "edge sample count", part, 2 * (cfg_k - 1));
        chk(outv[s - 1] == 0, "R3", "before step", outv[s - 1], 0);
        chk(outv[s + cfg_l + cfg_k - 1] == 0, "R3", "after trapezoid",
            outv[s + cfg_l + cfg_k - 1], 0);
        chk(outv[s] > 0 && outv[s] < outv[s + 1], "R3", "rising edge", outv[s], 125);
    endtask

    task automatic t_exp();
        int s, n;
        begin_scn(40, 3, 8192);
        s = cfg_l + cfg_k + 2;
        n = s + cfg_l + cfg_k + 20;
        xs[s] = 8000;
        for (int i = s; i < n - 1; i++) xs[i + 1] = xs[i] - ((xs[i] * 8192) >>> 16);
        stream(n, 0);
        for (int i = s + cfg_k - 1; i <= s + cfg_l - 1; i++)
            chk(outv[i] >= 8000 - cfg_l - 1 && outv[i] <= 8000 + cfg_l + 1,
                "R4", "flat top", outv[i], 8000);
        for (int i = s + cfg_l + cfg_k - 1; i < n; i++)
            chk(outv[i] >= -cfg_l - 1 && outv[i] <= cfg_l + 1,
                "R4", "tail baseline", outv[i], 0);
    endtask

    task automatic t_gaps();
        int n;
        n = 80;
        begin_scn(12, 2, 20000);
        for (int i = 0; i < n; i++) xs[i] = rnd();
        stream(n, 3);
        // R5: same pulse count as a gapless stream; values checked by monitor
        chk(vcount == n - (cfg_l + cfg_k - 1), "R5", "result count with gaps",
            vcount, n - (cfg_l + cfg_k - 1));
        chk(outv[n - 1] == yexp(n - 1), "R5", "last value with gaps", outv[n - 1], yexp(n - 1));
    endtask

    task automatic t_prime();
        int n;
        n = 30;
        begin_scn(5, 2, 40000);
        for (int i = 0; i < n; i++) xs[i] = rnd();
        stream(n, 0);
        chk(vcount == n - (cfg_l + cfg_k - 1), "R7", "pulse count",
            vcount, n - (cfg_l + cfg_k - 1));
        chk(outv[cfg_l + cfg_k - 2] == NONE, "R7", "last primed-out sample",
            outv[cfg_l + cfg_k - 2], NONE);
        chk(outv[cfg_l + cfg_k - 1] != NONE, "R7", "first valid sample",
            outv[cfg_l + cfg_k - 1], yexp(cfg_l + cfg_k - 1));
    endtask

    task automatic t_extreme();
        int n;
        n = 300;
        begin_scn(64, 5, 262143);
        for (int i = 0; i < n; i++) xs[i] = (((i / 64) % 2) == 0) ? 8191 : -8192;
        stream(n, 0);
        chk(outv[150] == yexp(150), "R8", "full-scale value", outv[150], yexp(150));
        chk(outv[n - 1] == yexp(n - 1), "R8", "full-scale end", outv[n - 1], yexp(n - 1));
    endtask

    task automatic t_small();
        int n;
        n = 60;
        begin_scn(2, 0, 65536);
        for (int i = 0; i < n; i++) xs[i] = rnd();
        stream(n, 0);
        chk(vcount == n - 2, "R9", "smallest window count", vcount, n - 2);
        chk(outv[30] == yexp(30), "R9", "smallest window value", outv[30], yexp(30));
    endtask

    initial begin
        rst      = 1'b1;
        smp_vld  = 1'b0;
        smp_data = '0;
        win_len  = 7'd8;
        avg_log2 = 3'd2;
        inv_tau  = '0;
        t_step();
        t_exp();
        t_gaps();
        t_prime();
        t_extreme();
        t_small();
        do_reset(); // R1 again after activity
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule